// File: doc/BRIEF.md
# Randomized-Placement Write-Through Cache Controller

This block is a small set-associative cache controller for timing-analysable processors. Before it reaches the tag and data arrays, the set index of every access passes through a keyed bit-permutation network. The key mixes the address bits above the index with a seed register, which software reloads at the start of each run. Inside one cache-way-sized segment (the addresses that share their upper bits), distinct lines always land in distinct sets. Which set a line lands in changes from seed to seed, so cache layouts become random across runs while spatial locality is kept.

The cache is write-through and allocates only on read misses. Because the placement is a bijection for each segment, a hit is decided on the upper address bits alone and no index bits are stored. Reloading the seed starts a sweep that clears the valid bits one set per clock cycle, and the CPU stalls until the sweep ends. A refill picks the first invalid way of the set. If every way is valid, a free-running LFSR picks the victim. The CPU port takes one request at a time. The memory port moves one word per handshake, both for line refills and for forwarded stores.

Top module: `rmc_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, with no request pending, cpu_ready, mem_rd and mem_wr are all low.
- R2: A read miss reads the full 32-byte line as 8 word reads. The reads start at the line base (address bits [4:0] zero) and step up by 4. Each read is held until mem_ack. The response returns the requested word, selected by address bits [4:2].
- R3: A read hit makes no memory access. cpu_ready pulses for exactly one cycle, two clock edges after the edge that samples the request. The requester drops cpu_rd/cpu_wr in that ready cycle.
- R4: A write hit updates the cached word, so a following read of that address hits and returns the written value.
- R5: A write miss does not allocate: a following read of that address misses (8 word reads) and returns the written value from memory.
- R6: A seed load clears the valid bits, one set per cycle, for all SETS sets. Throughout the sweep cpu_ready stays low and the memory port is idle. Afterwards every previously cached line misses.
- R7: A seed load that arrives in the same cycle a request is accepted, or later, takes effect only after that request completes. The request is served under the old placement.
- R8: Under one seed, the 128 lines of one segment occupy 128 distinct sets. Tags are address bits [31:12], index bits are [11:5], and only the tag is compared. As a result, four segments (512 lines) stay fully resident.
- R9: Every write is forwarded to memory exactly once. It carries the word-aligned address and the data, both held stable until mem_ack, and mem_rd and mem_wr are never high together.
- R10: A read miss always allocates. It uses an invalid way if one exists, and otherwise evicts the way chosen by the free-running LFSR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| seed_load | input | 1 | Request a new placement seed |
| seed_in | input | SEED_W | Seed value captured with seed_load |
| cpu_rd | input | 1 | Read request, held until cpu_ready |
| cpu_wr | input | 1 | Write request, held until cpu_ready |
| cpu_addr | input | AW | Byte address of the request |
| cpu_wdata | input | DW | Write data |
| cpu_ready | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | DW | Read data, valid with cpu_ready |
| mem_rd | output | 1 | Memory word read request |
| mem_wr | output | 1 | Memory word write request |
| mem_addr | output | AW | Word-aligned memory address |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data, valid with mem_ack |
| mem_ack | input | 1 | Memory handshake completion |

## Verification
A hit responds two edges after its request is sampled. A write responds one cycle after its store is acknowledged. A miss responds once the eighth refill word is acknowledged, and a request that arrives behind a seed load waits out the whole sweep first. The bench drives every input and samples every output on the falling edge. It counts falling edges from the request to the ready pulse, so an exact latency is checked where one is fixed (hits and hit writes). Where the latency depends on memory, it checks a bound instead (longer than SETS cycles after a seed load). The memory responder counts the word reads and writes of each access and checks their addresses against the line base. Hits, misses and the absence of stale hits are therefore judged from the ports alone.

// File: rtl/rmc_pkg.sv
package rmc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SWEEP,
    ST_LOOKUP,
    ST_FILL,
    ST_WTHRU,
    ST_RESP
  } rmc_state_e;

endpackage

// File: rtl/rmc_lfsr.sv
// Free-running Galois LFSR used as the replacement random source.
module rmc_lfsr #(
  parameter int              W     = 16,
  parameter logic [W-1:0]    TAPS  = 16'hB400,
  parameter logic [W-1:0]    START = 16'hACE1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  output logic [W-1:0] q
);

  logic [W-1:0] q_d;

  always_comb begin
    q_d = q;
    if (en) q_d = (q >> 1) ^ (q[0] ? TAPS : '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= START;
    else        q <= q_d;
  end

endmodule

// File: rtl/rmc_place.sv
// Keyed index permuter: odd-even transposition network of IDX_W stages.
// Each switch swaps two adjacent index bits, so the mapping is a bijection
// of the index for any key; the key folds the tag and the seed.
module rmc_place #(
  parameter int IDX_W  = 7,
  parameter int TAG_W  = 20,
  parameter int SEED_W = 32
) (
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [TAG_W-1:0]  tag_i,
  input  logic [SEED_W-1:0] seed_i,
  output logic [IDX_W-1:0]  set_o
);

  localparam int CW = IDX_W * (IDX_W - 1) / 2;

  logic [CW-1:0]    key;
  logic [IDX_W-1:0] v;
  logic             t;
  int               c;

  always_comb begin
    key = '0;
    for (int i = 0; i < TAG_W; i++)  key[i % CW] = key[i % CW] ^ tag_i[i];
    for (int i = 0; i < SEED_W; i++) key[i % CW] = key[i % CW] ^ seed_i[i];
    v = idx_i;
    c = 0;
    t = 1'b0;
    for (int s = 0; s < IDX_W; s++) begin
      for (int j = s % 2; j + 1 < IDX_W; j += 2) begin
        if (key[c]) begin
          t      = v[j];
          v[j]   = v[j+1];
          v[j+1] = t;
        end
        c++;
      end
    end
    set_o = v;
  end

endmodule

// File: rtl/rmc_store.sv
// Tag, valid and data arrays. Valid bits reset and can be cleared per set.
module rmc_store #(
  parameter int WAYS  = 4,
  parameter int SETS  = 128,
  parameter int WORDS = 8,
  parameter int TAG_W = 20,
  parameter int DW    = 32,
  localparam int IDX_W  = $clog2(SETS),
  localparam int WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1,
  localparam int WOFF_W = $clog2(WORDS)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [IDX_W-1:0]            set_i,
  output logic [WAYS-1:0][TAG_W-1:0]  tags_o,
  output logic [WAYS-1:0]             valid_o,
  input  logic [WAY_W-1:0]            rd_way_i,
  input  logic [WOFF_W-1:0]           rd_word_i,
  output logic [DW-1:0]               rd_data_o,
  input  logic                        wr_en_i,
  input  logic [WAY_W-1:0]            wr_way_i,
  input  logic [WOFF_W-1:0]           wr_word_i,
  input  logic [DW-1:0]               wr_data_i,
  input  logic                        tag_en_i,
  input  logic [TAG_W-1:0]            tag_i,
  input  logic                        clr_en_i,
  input  logic [IDX_W-1:0]            clr_set_i
);

  logic [TAG_W-1:0] tag_mem [WAYS][SETS];
  logic [DW-1:0]    dat_mem [WAYS][SETS][WORDS];

  always_ff @(posedge clk) begin
    if (wr_en_i)  dat_mem[wr_way_i][set_i][wr_word_i] <= wr_data_i;
    if (tag_en_i) tag_mem[wr_way_i][set_i]            <= tag_i;
  end

  assign rd_data_o = dat_mem[rd_way_i][set_i][rd_word_i];

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic [SETS-1:0] vld_q;
    logic [SETS-1:0] vld_d;

    always_comb begin
      vld_d = vld_q;
      if (clr_en_i) vld_d[clr_set_i] = 1'b0;
      if (tag_en_i && (wr_way_i == WAY_W'(w))) vld_d[set_i] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) vld_q <= '0;
      else        vld_q <= vld_d;
    end

    assign valid_o[w] = vld_q[set_i];
    assign tags_o[w]  = tag_mem[w][set_i];
  end

endmodule

// File: rtl/rmc_ctrl.sv
module rmc_ctrl #(
  parameter int AW         = 32,
  parameter int DW         = 32,
  parameter int LINE_BYTES = 32,
  parameter int WAYS       = 4,
  parameter int SETS       = 128,
  parameter int SEED_W     = 32,
  parameter int LFSR_W     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              seed_load,
  input  logic [SEED_W-1:0] seed_in,
  input  logic              cpu_rd,
  input  logic              cpu_wr,
  input  logic [AW-1:0]     cpu_addr,
  input  logic [DW-1:0]     cpu_wdata,
  output logic              cpu_ready,
  output logic [DW-1:0]     cpu_rdata,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [AW-1:0]     mem_addr,
  output logic [DW-1:0]     mem_wdata,
  input  logic [DW-1:0]     mem_rdata,
  input  logic              mem_ack
);
  import rmc_pkg::*;

  localparam int BYTE_W = $clog2(DW / 8);
  localparam int WORDS  = LINE_BYTES / (DW / 8);
  localparam int WOFF_W = $clog2(WORDS);
  localparam int OFF_W  = BYTE_W + WOFF_W;
  localparam int IDX_W  = $clog2(SETS);
  localparam int TAG_W  = AW - OFF_W - IDX_W;
  localparam int WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1;

  rmc_state_e            state_q, state_d;
  logic [AW-1:BYTE_W]    req_addr_q;
  logic [DW-1:0]         req_wdata_q;
  logic                  req_wr_q;
  logic [DW-1:0]         rdata_q, rdata_d;
  logic [SEED_W-1:0]     seed_q, seed_new_q;
  logic                  pend_q, pend_d;
  logic [IDX_W-1:0]      sweep_q, sweep_d;
  logic [WOFF_W-1:0]     fill_q, fill_d;
  logic [WAY_W-1:0]      victim_q, victim_d;
  logic                  req_ld, seed_apply;

  logic [TAG_W-1:0]             req_tag;
  logic [IDX_W-1:0]             req_idx, set_idx;
  logic [WOFF_W-1:0]            req_word;
  logic [WAYS-1:0][TAG_W-1:0]   st_tags;
  logic [WAYS-1:0]              st_valid, hit_vec;
  logic                         hit_any;
  logic [WAY_W-1:0]             hit_way, pick_way, rnd_way;
  logic [DW-1:0]                st_rd_data;
  logic                         st_wr_en, st_tag_en, st_clr_en;
  logic [WAY_W-1:0]             st_wr_way;
  logic [WOFF_W-1:0]            st_wr_word;
  logic [DW-1:0]                st_wr_data;
  logic [LFSR_W-1:0]            lfsr_q;
  logic                         sweep_busy;
  logic                         unused_byte_bits;

  assign unused_byte_bits = ^cpu_addr[BYTE_W-1:0];

  assign req_tag  = req_addr_q[AW-1 -: TAG_W];
  assign req_idx  = req_addr_q[OFF_W +: IDX_W];
  assign req_word = req_addr_q[BYTE_W +: WOFF_W];

  rmc_place #(.IDX_W(IDX_W), .TAG_W(TAG_W), .SEED_W(SEED_W)) i_place (
    .idx_i (req_idx),
    .tag_i (req_tag),
    .seed_i(seed_q),
    .set_o (set_idx)
  );

  rmc_lfsr #(.W(LFSR_W)) i_lfsr (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (1'b1),
    .q    (lfsr_q)
  );

  rmc_store #(.WAYS(WAYS), .SETS(SETS), .WORDS(WORDS), .TAG_W(TAG_W), .DW(DW)) i_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_i    (set_idx),
    .tags_o   (st_tags),
    .valid_o  (st_valid),
    .rd_way_i (hit_way),
    .rd_word_i(req_word),
    .rd_data_o(st_rd_data),
    .wr_en_i  (st_wr_en),
    .wr_way_i (st_wr_way),
    .wr_word_i(st_wr_word),
    .wr_data_i(st_wr_data),
    .tag_en_i (st_tag_en),
    .tag_i    (req_tag),
    .clr_en_i (st_clr_en),
    .clr_set_i(sweep_q)
  );

  // Per-way tag compare on upper address bits only
  for (genvar w = 0; w < WAYS; w++) begin : g_hit
    assign hit_vec[w] = st_valid[w] && (st_tags[w] == req_tag);
  end
  assign hit_any = |hit_vec;

  always_comb begin
    hit_way = '0;
    for (int w = 0; w < WAYS; w++) if (hit_vec[w]) hit_way = WAY_W'(w);
  end

  // Victim: lowest invalid way, else folded LFSR bits
  always_comb begin
    rnd_way = '0;
    for (int i = 0; i < LFSR_W; i++) rnd_way[i % WAY_W] = rnd_way[i % WAY_W] ^ lfsr_q[i];
    pick_way = rnd_way;
    for (int w = WAYS - 1; w >= 0; w--) if (!st_valid[w]) pick_way = WAY_W'(w);
  end

  // Next-state logic
  always_comb begin
    state_d    = state_q;
    sweep_d    = sweep_q;
    fill_d     = fill_q;
    victim_d   = victim_q;
    rdata_d    = rdata_q;
    req_ld     = 1'b0;
    seed_apply = 1'b0;
    st_wr_en   = 1'b0;
    st_tag_en  = 1'b0;
    st_clr_en  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (pend_q) begin
          seed_apply = 1'b1;
          sweep_d    = '0;
          state_d    = ST_SWEEP;
        end else if (cpu_rd || cpu_wr) begin
          req_ld  = 1'b1;
          state_d = ST_LOOKUP;
        end
      end
      ST_SWEEP: begin
        st_clr_en = 1'b1;
        sweep_d   = sweep_q + 1'b1;
        if (sweep_q == IDX_W'(SETS - 1)) state_d = ST_IDLE;
      end
      ST_LOOKUP: begin
        if (req_wr_q) begin
          st_wr_en = hit_any;
          state_d  = ST_WTHRU;
        end else if (hit_any) begin
          rdata_d = st_rd_data;
          state_d = ST_RESP;
        end else begin
          victim_d = pick_way;
          fill_d   = '0;
          state_d  = ST_FILL;
        end
      end
      ST_FILL: begin
        if (mem_ack) begin
          st_wr_en = 1'b1;
          if (fill_q == req_word) rdata_d = mem_rdata;
          fill_d = fill_q + 1'b1;
          if (fill_q == WOFF_W'(WORDS - 1)) begin
            st_tag_en = 1'b1;
            state_d   = ST_RESP;
          end
        end
      end
      ST_WTHRU: begin
        if (mem_ack) state_d = ST_RESP;
      end
      ST_RESP: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  assign st_wr_way  = (state_q == ST_FILL) ? victim_q  : hit_way;
  assign st_wr_word = (state_q == ST_FILL) ? fill_q    : req_word;
  assign st_wr_data = (state_q == ST_FILL) ? mem_rdata : req_wdata_q;

  always_comb begin
    pend_d = pend_q;
    if (seed_apply) pend_d = 1'b0;
    if (seed_load)  pend_d = 1'b1;
  end

  // Control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      pend_q   <= 1'b0;
      seed_q   <= '0;
      sweep_q  <= '0;
      fill_q   <= '0;
      victim_q <= '0;
    end else begin
      state_q  <= state_d;
      pend_q   <= pend_d;
      sweep_q  <= sweep_d;
      fill_q   <= fill_d;
      victim_q <= victim_d;
      if (seed_apply) seed_q <= seed_new_q;
    end
  end

  // Datapath registers with explicit enables
  always_ff @(posedge clk) begin
    if (seed_load) seed_new_q <= seed_in;
    if (req_ld) begin
      req_addr_q  <= cpu_addr[AW-1:BYTE_W];
      req_wdata_q <= cpu_wdata;
      req_wr_q    <= cpu_wr;
    end
    rdata_q <= rdata_d;
  end

  assign sweep_busy = (state_q == ST_SWEEP);
  assign cpu_ready  = (state_q == ST_RESP);
  assign cpu_rdata  = rdata_q;
  assign mem_rd     = (state_q == ST_FILL);
  assign mem_wr     = (state_q == ST_WTHRU);
  assign mem_wdata  = req_wdata_q;
  assign mem_addr   = (state_q == ST_FILL)
                    ? {req_addr_q[AW-1:OFF_W], fill_q, {BYTE_W{1'b0}}}
                    : {req_addr_q, {BYTE_W{1'b0}}};

endmodule

// File: rtl/rmc_check.sv
module rmc_check #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cpu_ready,
  input logic          mem_rd,
  input logic          mem_wr,
  input logic          mem_ack,
  input logic [AW-1:0] mem_addr,
  input logic [DW-1:0] mem_wdata,
  input logic          sweep_busy
);

  p_port_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));

  p_ready_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |=> !cpu_ready);

  p_sweep_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sweep_busy |-> (!cpu_ready && !mem_rd && !mem_wr));

  p_store_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr && !mem_ack) |=> (mem_wr && $stable(mem_addr) && $stable(mem_wdata)));

  p_fill_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && !mem_ack) |=> (mem_rd && $stable(mem_addr)));

  p_fill_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && mem_ack) |=> (!mem_rd || (mem_addr == $past(mem_addr) + AW'(DW / 8))));

endmodule

bind rmc_ctrl rmc_check #(.AW(AW), .DW(DW)) i_rmc_check (
  .clk       (clk),
  .rst_n     (rst_n),
  .cpu_ready (cpu_ready),
  .mem_rd    (mem_rd),
  .mem_wr    (mem_wr),
  .mem_ack   (mem_ack),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata),
  .sweep_busy(sweep_busy)
);

// File: tb/test_rmc_ctrl.sv
`timescale 1ns/1ps
module test_rmc_ctrl;

  localparam int SETS = 128;

  logic        clk, rst_n;
  logic        seed_load;
  logic [31:0] seed_in;
  logic        cpu_rd, cpu_wr;
  logic [31:0] cpu_addr, cpu_wdata, cpu_rdata;
  logic        cpu_ready;
  logic        mem_rd, mem_wr, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;

  int n_chk = 0;
  int n_bad = 0;
  int rd_cnt, wr_cnt, ord_bad;
  logic [31:0] last_ra, last_wa, last_wd;
  logic [31:0] mem_model [logic [31:0]];

  rmc_ctrl i_rmc_ctrl (
    .clk(clk), .rst_n(rst_n), .seed_load(seed_load), .seed_in(seed_in),
    .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack)
  );

  initial begin
    clk = 1'b0;
    forever #4 clk = ~clk;
  end

  function automatic logic [31:0] mdef(input logic [31:0] a);
    return (a * 32'h9E37_79B1) ^ 32'hC0FF_EE00;
  endfunction

  function automatic logic [31:0] mread(input logic [31:0] a);
    if (mem_model.exists(a)) return mem_model[a];
    return mdef(a);
  endfunction

  // Flat memory model: acknowledges one word every other cycle
  initial begin
    mem_ack = 1'b0;
    mem_rdata = '0;
    rd_cnt = 0; wr_cnt = 0; ord_bad = 0;
    last_ra = '0; last_wa = '0; last_wd = '0;
    forever begin
      @(negedge clk);
      if (mem_ack) mem_ack = 1'b0;
      else if (mem_rd) begin
        if (rd_cnt == 0) begin
          if (mem_addr[4:0] != 5'd0) ord_bad++;
        end else if (mem_addr != last_ra + 32'd4) ord_bad++;
        last_ra   = mem_addr;
        rd_cnt++;
        mem_rdata = mread(mem_addr);
        mem_ack   = 1'b1;
      end else if (mem_wr) begin
        mem_model[mem_addr] = mem_wdata;
        wr_cnt++;
        last_wa = mem_addr;
        last_wd = mem_wdata;
        mem_ack = 1'b1;
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic access(input bit wr, input logic [31:0] a, input logic [31:0] d,
                        input bit with_seed, input logic [31:0] s,
                        output logic [31:0] rd, output int cyc);
    @(negedge clk);
    rd_cnt = 0; wr_cnt = 0; ord_bad = 0;
    cpu_rd = !wr; cpu_wr = wr; cpu_addr = a; cpu_wdata = d;
    if (with_seed) begin seed_load = 1'b1; seed_in = s; end
    cyc = 0;
    do begin
      @(negedge clk);
      seed_load = 1'b0;
      cyc++;
    end while (!cpu_ready && cyc < 5000);
    rd = cpu_rdata;
    cpu_rd = 1'b0; cpu_wr = 1'b0;
  endtask

  task automatic load_seed(input logic [31:0] s);
    @(negedge clk);
    seed_load = 1'b1; seed_in = s;
    @(negedge clk);
    seed_load = 1'b0;
  endtask

  localparam logic [31:0] ADDR_A = 32'h0000_1234;
  localparam logic [31:0] ADDR_B = 32'h0002_0040;

  task automatic t_reset;
    chk("R1 ready", {31'd0, cpu_ready}, 32'd0);
    chk("R1 mem_rd", {31'd0, mem_rd}, 32'd0);
    chk("R1 mem_wr", {31'd0, mem_wr}, 32'd0);
  endtask

  task automatic t_read_miss;
    logic [31:0] r; int c;
    access(1'b0, ADDR_A, '0, 1'b0, '0, r, c);
    chk("R2 miss data", r, mread(ADDR_A));
    chk("R2 refill words", rd_cnt, 32'd8);
    chk("R2 refill order", ord_bad, 32'd0);
  endtask

  task automatic t_read_hit;
    logic [31:0] r; int c;
    access(1'b0, ADDR_A, '0, 1'b0, '0, r, c);
    chk("R3 hit data", r, mread(ADDR_A));
    chk("R3 hit latency", c, 32'd2);
    chk("R3 hit no traffic", rd_cnt + wr_cnt, 32'd0);
    access(1'b0, 32'h0000_1220, '0, 1'b0, '0, r, c);
    chk("R3 other word hit", rd_cnt, 32'd0);
    chk("R3 other word data", r, mread(32'h0000_1220));
  endtask

  task automatic t_write_hit;
    logic [31:0] r; int c;
    access(1'b1, ADDR_A, 32'hDEAD_BEEF, 1'b0, '0, r, c);
    chk("R9 one store", wr_cnt, 32'd1);
    chk("R9 store addr", last_wa, ADDR_A & 32'hFFFF_FFFC);
    chk("R9 store data", last_wd, 32'hDEAD_BEEF);
    chk("R4 write latency", c, 32'd3);
    access(1'b0, ADDR_A, '0, 1'b0, '0, r, c);
    chk("R4 read after write hit", rd_cnt, 32'd0);
    chk("R4 updated word", r, 32'hDEAD_BEEF);
  endtask

  task automatic t_write_miss;
    logic [31:0] r; int c;
    access(1'b1, ADDR_B, 32'h1234_5678, 1'b0, '0, r, c);
    chk("R5 no refill on write", rd_cnt, 32'd0);
    chk("R9 miss store forwarded", wr_cnt, 32'd1);
    access(1'b0, ADDR_B, '0, 1'b0, '0, r, c);
    chk("R5 no allocation", rd_cnt, 32'd8);
    chk("R5 data from memory", r, 32'h1234_5678);
  endtask

  task automatic t_seed_sweep;
    logic [31:0] r; int c;
    load_seed(32'h1357_9BDF);
    access(1'b0, ADDR_A, '0, 1'b0, '0, r, c);
    chk("R6 stall covers sweep", {31'd0, c > SETS}, 32'd1);
    chk("R6 no stale hit", rd_cnt, 32'd8);
    chk("R6 last written value", r, 32'hDEAD_BEEF);
  endtask

  task automatic t_seed_defer;
    logic [31:0] r; int c;
    access(1'b0, ADDR_A, '0, 1'b1, 32'h2468_ACE0, r, c);
    chk("R7 served under old seed", rd_cnt, 32'd0);
    chk("R7 latency", c, 32'd2);
    access(1'b0, ADDR_A, '0, 1'b0, '0, r, c);
    chk("R7 seed applied after", rd_cnt, 32'd8);
    chk("R7 data", r, 32'hDEAD_BEEF);
  endtask

  function automatic logic [31:0] cap_addr(input int seg, input int line);
    return 32'h0010_0000 + 32'(seg * 4096) + 32'(line * 32) + 32'((line % 8) * 4);
  endfunction

  task automatic t_capacity;
    logic [31:0] r; int c; int reads; int bad;
    load_seed(32'h0BAD_F00D);
    reads = 0; bad = 0;
    for (int seg = 0; seg < 4; seg++)
      for (int ln = 0; ln < SETS; ln++) begin
        access(1'b0, cap_addr(seg, ln), '0, 1'b0, '0, r, c);
        reads += rd_cnt;
        if (r !== mread(cap_addr(seg, ln))) bad++;
      end
    chk("R8 fill pass reads", reads, 32'(4 * SETS * 8));
    chk("R8 fill pass data", bad, 32'd0);
    reads = 0; bad = 0;
    for (int seg = 0; seg < 4; seg++)
      for (int ln = 0; ln < SETS; ln++) begin
        access(1'b0, cap_addr(seg, ln), '0, 1'b0, '0, r, c);
        reads += rd_cnt;
        if (r !== mread(cap_addr(seg, ln))) bad++;
      end
    chk("R8 all resident", reads, 32'd0);
    chk("R8 reread data", bad, 32'd0);
  endtask

  task automatic t_full_set;
    logic [31:0] r; int c; int misses;
    access(1'b0, cap_addr(4, 3), '0, 1'b0, '0, r, c);
    chk("R10 full set miss", rd_cnt, 32'd8);
    access(1'b0, cap_addr(4, 3), '0, 1'b0, '0, r, c);
    chk("R10 allocated in full set", rd_cnt, 32'd0);
    chk("R10 data", r, mread(cap_addr(4, 3)));
    misses = 0;
    for (int seg = 0; seg < 4; seg++)
      for (int ln = 0; ln < SETS; ln++) begin
        access(1'b0, cap_addr(seg, ln), '0, 1'b0, '0, r, c);
        if (rd_cnt > 0) misses++;
      end
    chk("R10 one line evicted", {31'd0, misses > 0}, 32'd1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    seed_load = 1'b0; seed_in = '0;
    cpu_rd = 1'b0; cpu_wr = 1'b0; cpu_addr = '0; cpu_wdata = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_read_miss();
    t_read_hit();
    t_write_hit();
    t_write_miss();
    t_seed_sweep();
    t_seed_defer();
    t_capacity();
    t_full_set();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule